// File: doc/BRIEF.md
# Snooping MESI Cache-Line Controller

This block keeps the coherence state of each line in a small direct-mapped write-back cache that sits on a shared snooping bus. It handles two kinds of traffic. The first is processor reads and writes. The second is transactions that other caches place on the bus, which arrive here as snoops. For each of these it works out the next line state and any bus action that is needed. The bus actions are a read, a read-for-ownership, a writeback of a dirty victim, and a flush of dirty data in answer to a snoop.

The controller has four line states: Invalid, Shared, Exclusive-clean and Modified. A read miss samples the wired-OR shared line at bus grant. If another cache holds the line, the fill is Shared. If not, the fill is Exclusive-clean, and a later write to that line needs no bus traffic. The controller also drives the shared line whenever a snooped read hits one of its valid lines.

A processor request raises a bus request and shows busy until the external arbiter grants the bus. Snoops are always handled first. A grant that arrives in the same cycle as a snoop is not taken, and the request stays up. The processor holds its request, address and write flag until it sees the one-cycle done pulse. That pulse reports the state the addressed line has after the operation.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid. In that state busy, done, bus request, shared-out and flush are all low, and no snoop gets a response.
- R2: A read miss requests the bus with command RD (01) and the request address. At grant the line fills Exclusive-clean (10) if the shared-in input is low, and Shared (01) if it is high.
- R3: A read that hits in Shared, Exclusive-clean or Modified completes with no bus request and leaves the state unchanged. Done is a one-cycle pulse that comes with the line state, encoded I=00, S=01, E=10, M=11.
- R4: A write that hits in Exclusive-clean or Modified makes the line Modified with no bus request.
- R5: A write to a Shared line, or a write miss, requests the bus with command RDX (10), and the line becomes Modified at grant.
- R6: A snooped RD (01) that hits a valid line asserts shared-out in the same cycle. If the line is Modified, flush is asserted as well. A hit in Exclusive-clean or Modified leaves the line Shared.
- R7: A snooped RDX (10) that hits a valid line leaves it Invalid. Flush is asserted only when the line was Modified, and shared-out stays low.
- R8: On a miss whose victim is Modified, the controller first writes the victim back with command WB (11) and the victim's address, then issues the fill request. A victim that is not Modified is dropped without a writeback.
- R9: While a request that needs the bus is waiting for grant, the addressed line keeps its old state. Snoops therefore see the old state.
- R10: Busy is high while a bus request is outstanding, and the command and address are held until they are granted. A grant in a cycle that also carries a snoop is ignored: the snoop is serviced and the request stays up.
- R11: A snoop that misses has no effect: no shared-out, no flush and no state change. A miss means an Invalid line or a different tag. A snoop whose command is neither RD nor RDX has no effect either.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, held until done |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW | Line address (low bits select the index) |
| cpu_busy | output | 1 | Request waiting on the bus |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_line_st | output | 2 | Line state after the completed request |
| bus_req | output | 1 | Bus request |
| bus_cmd | output | 2 | RD=01, RDX=10, WB=11 |
| bus_addr | output | AW | Address of the requested transaction |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| bus_shared_in | input | 1 | Wired-OR shared line, sampled at RD grant |
| snp_valid | input | 1 | Snooped transaction present |
| snp_cmd | input | 2 | Snooped command |
| snp_addr | input | AW | Snooped line address |
| snp_shared_out | output | 1 | Drive of the wired-OR shared line |
| snp_flush | output | 1 | Put the dirty line's data on the bus |

## Verification
Two functions can land in the same cycle: a snoop, and the arbiter's grant for the controller's own pending request. The bench provokes this by holding a write-to-Shared request pending. It then presents a snooped read to the same line together with a grant. It judges the result in three ways. The shared response must reflect the line's old Shared state, with no flush. The request must remain raised with the same RDX command afterwards. A later clean grant must still complete the line to Modified.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

  typedef enum logic [1:0] {
    LN_I = 2'b00,
    LN_S = 2'b01,
    LN_E = 2'b10,
    LN_M = 2'b11
  } line_st_t;

  typedef enum logic [1:0] {
    BC_NONE = 2'b00,
    BC_RD   = 2'b01,
    BC_RDX  = 2'b10,
    BC_WB   = 2'b11
  } bus_cmd_t;

  // state a line takes after a snooped command hits it
  function automatic line_st_t snoop_next(input line_st_t st, input bus_cmd_t cmd);
    case (cmd)
      BC_RD:   snoop_next = (st == LN_I) ? LN_I : LN_S;
      BC_RDX:  snoop_next = LN_I;
      default: snoop_next = st;
    endcase
  endfunction

  // state a line takes when its bus fill is granted
  function automatic line_st_t fill_state(input logic is_write, input logic shared);
    if (is_write)    fill_state = LN_M;
    else if (shared) fill_state = LN_S;
    else             fill_state = LN_E;
  endfunction

  // writes that can complete without the bus
  function automatic logic write_is_local(input line_st_t st);
    write_is_local = (st == LN_E) || (st == LN_M);
  endfunction

endpackage

// File: rtl/mesi_tag_store.sv
module mesi_tag_store
  import mesi_pkg::*;
#(
  parameter int NLINES = 4,
  parameter int TAGW   = 6,
  localparam int IDXW  = $clog2(NLINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDXW-1:0]  ra_idx,
  output logic [TAGW-1:0]  ra_tag,
  output line_st_t         ra_st,
  input  logic [IDXW-1:0]  rb_idx,
  output logic [TAGW-1:0]  rb_tag,
  output line_st_t         rb_st,
  input  logic             w_en,
  input  logic [IDXW-1:0]  w_idx,
  input  logic             w_tag_en,
  input  logic [TAGW-1:0]  w_tag,
  input  line_st_t         w_st
);

  logic [TAGW-1:0] tag_q [NLINES];
  line_st_t        st_q  [NLINES];

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st_q[g]  <= LN_I;
        tag_q[g] <= '0;
      end else if (w_en && (w_idx == IDXW'(g))) begin
        st_q[g] <= w_st;
        if (w_tag_en) tag_q[g] <= w_tag;
      end
    end
  end

  assign ra_tag = tag_q[ra_idx];
  assign ra_st  = st_q[ra_idx];
  assign rb_tag = tag_q[rb_idx];
  assign rb_st  = st_q[rb_idx];

endmodule

// File: rtl/mesi_snoop_unit.sv
module mesi_snoop_unit
  import mesi_pkg::*;
#(
  parameter int TAGW = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            snp_valid,
  input  bus_cmd_t        snp_cmd,
  input  logic [TAGW-1:0] snp_tag,
  input  logic [TAGW-1:0] line_tag,
  input  line_st_t        line_st,
  output logic            shared_out,
  output logic            flush,
  output logic            upd,
  output line_st_t        nxt_st
);

  logic hit;
  logic is_rd, is_rdx;

  assign hit        = snp_valid && (line_st != LN_I) && (line_tag == snp_tag);
  assign is_rd      = (snp_cmd == BC_RD);
  assign is_rdx     = (snp_cmd == BC_RDX);
  assign shared_out = hit && is_rd;
  assign flush      = hit && (is_rd || is_rdx) && (line_st == LN_M);
  assign nxt_st     = snoop_next(line_st, snp_cmd);
  assign upd        = hit && (nxt_st != line_st);

  AST_SHARED_ON_RD: assert property (@(posedge clk) disable iff (!rst_n)
    shared_out |-> (snp_valid && snp_cmd == BC_RD)); // R6

  AST_FLUSH_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (snp_valid && !shared_out |-> snp_cmd == BC_RDX)); // R7

endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
  import mesi_pkg::*;
#(
  parameter int AW     = 8,
  parameter int NLINES = 4,
  localparam int IDXW  = $clog2(NLINES),
  localparam int TAGW  = AW - IDXW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req,
  input  logic          cpu_wr,
  input  logic [AW-1:0] cpu_addr,
  output logic          cpu_busy,
  output logic          cpu_done,
  output logic [1:0]    cpu_line_st,
  output logic          bus_req,
  output logic [1:0]    bus_cmd,
  output logic [AW-1:0] bus_addr,
  input  logic          bus_gnt,
  input  logic          bus_shared_in,
  input  logic          snp_valid,
  input  logic [1:0]    snp_cmd,
  input  logic [AW-1:0] snp_addr,
  output logic          snp_shared_out,
  output logic          snp_flush
);

  typedef enum logic [1:0] {F_IDLE, F_WB, F_BUS, F_DONE} fsm_t;

  fsm_t      fsm_q;
  bus_cmd_t  req_cmd_q;
  line_st_t  done_st_q;

  logic [IDXW-1:0] c_idx, s_idx;
  logic [TAGW-1:0] c_tag, s_tag, c_tag_q, s_tag_q;
  line_st_t        c_st, s_st;
  logic            c_hit, accept, local_ok, gnt_ok;

  // store write port
  logic            w_en, w_tag_en;
  logic [IDXW-1:0] w_idx;
  line_st_t        w_st;
  logic            snp_upd, fsm_upd;
  line_st_t        snp_nxt;

  assign c_idx = cpu_addr[IDXW-1:0];
  assign c_tag = cpu_addr[AW-1:IDXW];
  assign s_idx = snp_addr[IDXW-1:0];
  assign s_tag = snp_addr[AW-1:IDXW];

  mesi_tag_store #(.NLINES(NLINES), .TAGW(TAGW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .ra_idx(c_idx), .ra_tag(c_tag_q), .ra_st(c_st),
    .rb_idx(s_idx), .rb_tag(s_tag_q), .rb_st(s_st),
    .w_en(w_en), .w_idx(w_idx), .w_tag_en(w_tag_en), .w_tag(c_tag), .w_st(w_st)
  );

  mesi_snoop_unit #(.TAGW(TAGW)) u_snoop (
    .clk(clk), .rst_n(rst_n),
    .snp_valid(snp_valid), .snp_cmd(bus_cmd_t'(snp_cmd)), .snp_tag(s_tag),
    .line_tag(s_tag_q), .line_st(s_st),
    .shared_out(snp_shared_out), .flush(snp_flush),
    .upd(snp_upd), .nxt_st(snp_nxt)
  );

  assign c_hit    = (c_st != LN_I) && (c_tag_q == c_tag);
  assign accept   = (fsm_q == F_IDLE) && cpu_req && !snp_valid;
  assign local_ok = c_hit && (!cpu_wr || write_is_local(c_st));

  // bus side: writeback of dirty victim, then the fill / ownership request
  assign bus_req  = ((fsm_q == F_WB) && (c_st == LN_M)) || (fsm_q == F_BUS);
  assign bus_cmd  = (fsm_q == F_WB) ? BC_WB : req_cmd_q;
  assign bus_addr = (fsm_q == F_WB) ? {c_tag_q, c_idx} : cpu_addr;
  assign gnt_ok   = bus_req && bus_gnt && !snp_valid;

  // single write port; snoop has priority, FSM writes never need it in the same cycle
  always_comb begin
    w_en     = 1'b0;
    w_idx    = c_idx;
    w_tag_en = 1'b0;
    w_st     = LN_I;
    fsm_upd  = 1'b0;
    if (snp_upd) begin
      w_en  = 1'b1;
      w_idx = s_idx;
      w_st  = snp_nxt;
    end else if (accept && local_ok && cpu_wr) begin
      w_en    = 1'b1;
      w_st    = LN_M;
      fsm_upd = 1'b1;
    end else if ((fsm_q == F_WB) && gnt_ok) begin
      w_en    = 1'b1;
      w_st    = LN_I;
      fsm_upd = 1'b1;
    end else if ((fsm_q == F_BUS) && gnt_ok) begin
      w_en     = 1'b1;
      w_tag_en = 1'b1;
      w_st     = fill_state(req_cmd_q == BC_RDX, bus_shared_in);
      fsm_upd  = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsm_q     <= F_IDLE;
      req_cmd_q <= BC_RD;
      done_st_q <= LN_I;
    end else begin
      case (fsm_q)
        F_IDLE: if (accept) begin
          if (local_ok) begin
            fsm_q     <= F_DONE;
            done_st_q <= cpu_wr ? LN_M : c_st;
          end else begin
            req_cmd_q <= cpu_wr ? BC_RDX : BC_RD;
            fsm_q     <= (!c_hit && c_st == LN_M) ? F_WB : F_BUS;
          end
        end
        F_WB: if (gnt_ok || c_st != LN_M) fsm_q <= F_BUS;
        F_BUS: if (gnt_ok) begin
          fsm_q     <= F_DONE;
          done_st_q <= fill_state(req_cmd_q == BC_RDX, bus_shared_in);
        end
        default: fsm_q <= F_IDLE;
      endcase
    end
  end

  assign cpu_busy    = (fsm_q == F_WB) || (fsm_q == F_BUS);
  assign cpu_done    = (fsm_q == F_DONE);
  assign cpu_line_st = done_st_q;

  AST_ONE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
    !(snp_upd && fsm_upd)); // R10

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt && !snp_valid) |=> (bus_req && $stable(bus_cmd) && $stable(bus_addr))); // R10

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |=> !cpu_done); // R3

  AST_BUSY_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_busy |-> !cpu_done); // R10

endmodule

// File: tb/tb_mesi_line_ctrl.sv
module tb_mesi_line_ctrl;

  localparam int AW = 8;
  localparam logic [1:0] ST_I = 2'd0, ST_S = 2'd1, ST_E = 2'd2, ST_M = 2'd3;
  localparam logic [1:0] C_RD = 2'd1, C_RDX = 2'd2, C_WB = 2'd3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_req = 1'b0, cpu_wr = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic cpu_busy, cpu_done;
  logic [1:0] cpu_line_st;
  logic bus_req;
  logic [1:0] bus_cmd;
  logic [AW-1:0] bus_addr;
  logic bus_gnt = 1'b0, bus_shared_in = 1'b0;
  logic snp_valid = 1'b0;
  logic [1:0] snp_cmd = '0;
  logic [AW-1:0] snp_addr = '0;
  logic snp_shared_out, snp_flush;

  always #2 clk = ~clk;

  mesi_line_ctrl #(.AW(AW), .NLINES(4)) dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_busy(cpu_busy), .cpu_done(cpu_done), .cpu_line_st(cpu_line_st),
    .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
    .bus_gnt(bus_gnt), .bus_shared_in(bus_shared_in),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
    .snp_shared_out(snp_shared_out), .snp_flush(snp_flush)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  typedef struct {
    logic [1:0]    cmd;
    logic [AW-1:0] addr;
    string         req;
  } bus_item_t;

  bus_item_t exp_q[$];

  task automatic expect_bus(input logic [1:0] c, input logic [AW-1:0] a, input string req);
    bus_item_t it;
    it.cmd = c; it.addr = a; it.req = req;
    exp_q.push_back(it);
  endtask

  // monitor: every granted transaction (no snoop in that cycle) is compared
  initial forever begin
    @(negedge clk); #1;
    if (rst_n && bus_req && bus_gnt && !snp_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R3", "unexpected bus transaction", int'({bus_cmd, bus_addr}), 0);
      end else begin
        bus_item_t it;
        it = exp_q.pop_front();
        check(bus_cmd == it.cmd, it.req, "bus command", bus_cmd, it.cmd);
        check(bus_addr == it.addr, it.req, "bus address", bus_addr, it.addr);
      end
    end
  end

  // driver: one processor access, granting every bus request it raises
  task automatic cpu_op(input bit wr, input logic [AW-1:0] a, input bit shr,
                        input logic [1:0] exp_st, input string req);
    bit got = 1'b0;
    @(negedge clk);
    cpu_req = 1'b1; cpu_wr = wr; cpu_addr = a;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      bus_gnt = 1'b0;
      if (cpu_done) begin
        check(cpu_line_st == exp_st, req, "line state", cpu_line_st, exp_st);
        got = 1'b1;
        break;
      end
      if (bus_req) begin
        bus_gnt = 1'b1;
        bus_shared_in = shr;
      end
    end
    if (!got) check(1'b0, req, "request completion", 0, 1);
    cpu_req = 1'b0;
    #2;
    check(exp_q.size() == 0, req, "expected bus items left", exp_q.size(), 0);
  endtask

  task automatic snoop(input logic [1:0] c, input logic [AW-1:0] a,
                       input bit exp_sh, input bit exp_fl, input string req);
    @(negedge clk);
    snp_valid = 1'b1; snp_cmd = c; snp_addr = a;
    #1;
    check(snp_shared_out == exp_sh, req, "shared out", snp_shared_out, exp_sh);
    check(snp_flush == exp_fl, req, "flush", snp_flush, exp_fl);
    @(negedge clk);
    snp_valid = 1'b0; snp_cmd = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "WD", "watchdog expired", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  localparam logic [AW-1:0] A = 8'h10, B = 8'h21, C = 8'h32, D = 8'h43,
                            F = 8'h83, G = 8'h72;

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset outputs
    check(!cpu_busy && !cpu_done, "R1", "busy/done in reset", {cpu_busy, cpu_done}, 0);
    check(!bus_req && !snp_shared_out && !snp_flush, "R1", "bus outputs in reset",
          {bus_req, snp_shared_out, snp_flush}, 0);
    rst_n = 1'b1;
    snoop(C_RD, A, 1'b0, 1'b0, "R1");

    // R2 / R3 / R6 basic read flow
    expect_bus(C_RD, A, "R2");
    cpu_op(1'b0, A, 1'b0, ST_E, "R2");
    cpu_op(1'b0, A, 1'b0, ST_E, "R3");
    snoop(C_RD, A, 1'b1, 1'b0, "R6");
    cpu_op(1'b0, A, 1'b0, ST_S, "R6");

    // R9 / R10: write to Shared line, snoop collides with grant
    expect_bus(C_RDX, A, "R5");
    @(negedge clk);
    cpu_req = 1'b1; cpu_wr = 1'b1; cpu_addr = A;
    @(negedge clk);
    check(bus_req && bus_cmd == C_RDX, "R5", "upgrade request", {bus_req, bus_cmd}, {1'b1, C_RDX});
    check(cpu_busy, "R10", "busy while pending", cpu_busy, 1);
    snp_valid = 1'b1; snp_cmd = C_RD; snp_addr = A; bus_gnt = 1'b1; bus_shared_in = 1'b0;
    #1;
    check(snp_shared_out, "R9", "old state seen by snoop (shared)", snp_shared_out, 1);
    check(!snp_flush, "R9", "old state seen by snoop (flush)", snp_flush, 0);
    @(negedge clk);
    snp_valid = 1'b0; snp_cmd = '0; bus_gnt = 1'b0;
    #1;
    check(bus_req && bus_cmd == C_RDX, "R10", "request held after collided grant",
          {bus_req, bus_cmd}, {1'b1, C_RDX});
    check(cpu_busy && !cpu_done, "R10", "still busy", {cpu_busy, cpu_done}, 2);
    bus_gnt = 1'b1;
    @(negedge clk);
    bus_gnt = 1'b0;
    check(cpu_done && cpu_line_st == ST_M, "R5", "upgrade completes Modified",
          {cpu_done, cpu_line_st}, {1'b1, ST_M});
    cpu_req = 1'b0; cpu_wr = 1'b0;
    #2;
    check(exp_q.size() == 0, "R10", "upgrade transaction seen", exp_q.size(), 0);

    cpu_op(1'b0, A, 1'b0, ST_M, "R3");
    snoop(C_RD, A, 1'b1, 1'b1, "R6");
    cpu_op(1'b0, A, 1'b0, ST_S, "R6");

    // shared fill, write to shared line
    expect_bus(C_RD, B, "R2");
    cpu_op(1'b0, B, 1'b1, ST_S, "R2");
    expect_bus(C_RDX, B, "R5");
    cpu_op(1'b1, B, 1'b0, ST_M, "R5");

    // exclusive-clean write, snooped ownership request
    expect_bus(C_RD, C, "R2");
    cpu_op(1'b0, C, 1'b0, ST_E, "R2");
    cpu_op(1'b1, C, 1'b0, ST_M, "R4");
    snoop(C_RDX, C, 1'b0, 1'b1, "R7");
    expect_bus(C_RD, C, "R7");
    cpu_op(1'b0, C, 1'b0, ST_E, "R7");

    // write miss, then dirty-victim replacement
    expect_bus(C_RDX, D, "R5");
    cpu_op(1'b1, D, 1'b0, ST_M, "R5");
    expect_bus(C_WB, D, "R8");
    expect_bus(C_RD, F, "R8");
    cpu_op(1'b0, F, 1'b0, ST_E, "R8");

    // clean victim dropped silently
    expect_bus(C_RD, G, "R8");
    cpu_op(1'b0, G, 1'b1, ST_S, "R8");
    snoop(C_RD, C, 1'b0, 1'b0, "R11");
    cpu_op(1'b0, G, 1'b0, ST_S, "R11");
    snoop(C_RDX, G, 1'b0, 1'b0, "R7");
    expect_bus(C_RD, G, "R7");
    cpu_op(1'b0, G, 1'b0, ST_E, "R7");

    // Modified line ignores a snooped writeback command
    cpu_op(1'b1, F, 1'b0, ST_M, "R4");
    snoop(C_WB, F, 1'b0, 1'b0, "R11");
    cpu_op(1'b0, F, 1'b0, ST_M, "R11");

    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule